// File: doc/BRIEF.md
# Floating-Point Coprocessor Instruction Snooping Controller

This block runs a single-precision floating-point coprocessor beside a 32-bit CPU whose instructions and data share one input bus. It watches that bus, takes in each word the CPU fetches, and decodes it at the same time as the CPU does. Words aimed at the coprocessor are carried out here, while the CPU treats them as no-ops. Arithmetic and conversions go to an external floating-point unit through a one-cycle start pulse, and the block waits for that unit's ready strobe. Absolute value, negate, move and compare are done locally. The block holds a 32 x 32-bit register file. While an instruction is in flight it raises busy, which stalls the CPU together with the memory pause line.

Data moves between the coprocessor and the CPU or memory take one transfer cycle right after the fetch. In that cycle a 4-bit select output steers the external bus multiplexers. Compare instructions set a condition flag, which the CPU uses for its branch-on-FP instructions. Exception flags from the arithmetic unit are not used.

The external unit applies back-pressure only through ready: after the start pulse the controller holds the operands and opcode and waits for as long as ready stays low. It takes the result in the first cycle in which ready is high.

Top module: `fp_copro_ctrl`

## Requirements
- R1: A word on `bus_in` is taken as an instruction only at a clock edge where `fetch_i` is high and the controller is idle. A coprocessor word present while `fetch_i` is low has no effect.
- R2: A word is acted on only if it is one of the following. A coprocessor word has bits 31:26 = 010001, with bits 25:21 = 10000 for arithmetic, 00100 for move-to and 00000 for move-from. A load has bits 31:26 = 110001 and a store has bits 31:26 = 111001. Any other word, and an arithmetic word whose function code is not listed in R5, R7 or R8, never raises busy, never drives the selects and never writes a register.
- R3: `busy_o` rises in the first cycle after the fetch edge of an arithmetic word and stays high through the cycle in which ready is accepted. For an external operation that is 2 + L cycles, where L is the number of cycles from start to ready. `stall_o` is high whenever `busy_o` or `mem_pause_i` is high.
- R4: The register file has 32 registers of 32 bits and resets to zero. Register fields are fd = bits 10:6, fs = 15:11 and ft = 20:16.
- R5: Function codes 0, 1, 2, 3, 32 and 36 (add, sub, mul, div, int-to-single, single-to-int) are sent to the external unit as opcodes 0 to 5. The value on `fpu_result_i` in the ready cycle is written to fd.
- R6: Operands fs and ft pass through a register stage. `fpu_start_o` is high for exactly one cycle, the second after the fetch edge, and it carries the operands and opcode at that point.
- R7: Function 5 clears bit 31 of fs, function 7 inverts it, and function 6 copies fs unchanged. The result goes to fd, and busy lasts 2 cycles.
- R8: Functions 48 to 63 compare fs with ft. Bit 2 of the function selects less-than, bit 1 selects equal and bit 0 selects unordered (either operand NaN). +0 and -0 compare equal. `fp_cond_o` takes the OR of the selected relations and holds it until the next compare.
- R9: In the transfer cycle right after a move fetch, exactly one select bit is high: bit 0 for move-from (fs on `data_out_o` to the CPU), bit 1 for store, bit 2 for move-to and bit 3 for load. For move-to and load, `bus_in` in that cycle is written to fs or ft respectively. No select bit is high in any other cycle.
- R10: A store drives register ft on `data_out_o` with `byte_we_o` = 1111, only in its transfer cycle. `byte_we_o` is 0000 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fetch_i | input | 1 | CPU is fetching an instruction this cycle |
| bus_in | input | 32 | Shared instruction/data input bus |
| mem_pause_i | input | 1 | Memory wait request |
| fpu_ready_i | input | 1 | External unit result valid |
| fpu_result_i | input | 32 | External unit result |
| busy_o | output | 1 | Coprocessor instruction in progress |
| stall_o | output | 1 | CPU pause (busy or memory wait) |
| fp_cond_o | output | 1 | Last compare outcome |
| bus_sel_o | output | 4 | External multiplexer selects |
| data_out_o | output | 32 | Register data to CPU or memory |
| byte_we_o | output | 4 | Byte enables for a coprocessor store |
| fpu_start_o | output | 1 | Start pulse to the external unit |
| fpu_op_o | output | 3 | External unit opcode |
| fpu_opa_o | output | 32 | Registered first operand |
| fpu_opb_o | output | 32 | Registered second operand |

## Verification
Each result has a fixed cycle. Busy is due in the first cycle after the fetch edge and the start pulse in the second. The write, or the new condition flag, becomes visible in the cycle after the ready edge, and for local operations in the third cycle after the fetch edge. Move selects, store enables and store data are due in the first cycle after the fetch edge. The bench drives inputs and samples outputs on falling edges, indexing every busy cycle from the fetch edge so that each check lands on its cycle. The external unit's latency is varied to confirm that busy tracks ready.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int unsigned XLEN    = 32;
  localparam int unsigned RFIELD  = 5;
  localparam logic [5:0]  OPC_COP = 6'b010001;
  localparam logic [5:0]  OPC_LD  = 6'b110001;
  localparam logic [5:0]  OPC_ST  = 6'b111001;
  localparam logic [4:0]  SUB_ARI = 5'b10000;
  localparam logic [4:0]  SUB_TO  = 5'b00100;
  localparam logic [4:0]  SUB_FROM = 5'b00000;

  typedef enum logic [2:0] {
    K_NONE, K_EXT, K_LOC, K_MFROM, K_MTO, K_LOAD, K_STORE
  } kind_e;

  typedef enum logic [1:0] {L_MOV, L_ABS, L_NEG, L_CMP} lop_e;

  typedef enum logic [2:0] {
    S_IDLE, S_OPRD, S_START, S_WAIT, S_LOCAL, S_XFER
  } state_e;

  typedef struct packed {
    kind_e             kind;
    logic [2:0]        fop;
    lop_e              lop;
    logic [3:0]        cond;
    logic [RFIELD-1:0] fd;
    logic [RFIELD-1:0] fs;
    logic [RFIELD-1:0] ft;
  } dec_t;
endpackage

// File: rtl/fpc_decode.sv
module fpc_decode
  import fpc_pkg::*;
(
  input  logic [XLEN-1:0] word,
  output dec_t            dec
);
  logic [5:0] func;
  assign func = word[5:0];

  always_comb begin
    dec      = '0;
    dec.kind = K_NONE;
    dec.lop  = L_MOV;
    dec.fd   = word[10:6];
    dec.fs   = word[15:11];
    dec.ft   = word[20:16];
    dec.cond = func[3:0];
    if (word[31:26] == OPC_LD) begin
      dec.kind = K_LOAD;
    end else if (word[31:26] == OPC_ST) begin
      dec.kind = K_STORE;
    end else if (word[31:26] == OPC_COP) begin
      if (word[25:21] == SUB_TO) begin
        dec.kind = K_MTO;
      end else if (word[25:21] == SUB_FROM) begin
        dec.kind = K_MFROM;
      end else if (word[25:21] == SUB_ARI) begin
        if (func[5:4] == 2'b11) begin
          dec.kind = K_LOC;
          dec.lop  = L_CMP;
        end else begin
          case (func)
            6'd0, 6'd1, 6'd2, 6'd3: begin
              dec.kind = K_EXT;
              dec.fop  = func[2:0];
            end
            6'd32: begin dec.kind = K_EXT; dec.fop = 3'd4; end
            6'd36: begin dec.kind = K_EXT; dec.fop = 3'd5; end
            6'd5:  begin dec.kind = K_LOC; dec.lop = L_ABS; end
            6'd6:  begin dec.kind = K_LOC; dec.lop = L_MOV; end
            6'd7:  begin dec.kind = K_LOC; dec.lop = L_NEG; end
            default: dec.kind = K_NONE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/fpc_regfile.sv
module fpc_regfile #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mem[i] <= '0;
      else if (we && waddr == AW'(i))      mem[i] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/fpc_local_unit.sv
module fpc_local_unit
  import fpc_pkg::*;
(
  input  lop_e            lop,
  input  logic [3:0]      cond,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res,
  output logic            cmp
);
  localparam int unsigned MANT = 23;
  localparam int unsigned SGN  = XLEN - 1;

  logic a_nan, b_nan, unord, both_zero, eq, lt, less;

  assign a_nan     = (&a[SGN-1:MANT]) && (|a[MANT-1:0]);
  assign b_nan     = (&b[SGN-1:MANT]) && (|b[MANT-1:0]);
  assign unord     = a_nan || b_nan;
  assign both_zero = ~|{a[SGN-1:0], b[SGN-1:0]};
  assign eq        = !unord && ((a == b) || both_zero);

  always_comb begin
    if (a[SGN] != b[SGN]) lt = a[SGN] && !both_zero;
    else if (!a[SGN])     lt = a[SGN-1:0] < b[SGN-1:0];
    else                  lt = a[SGN-1:0] > b[SGN-1:0];
  end

  assign less = !unord && lt;
  assign cmp  = (cond[2] && less) || (cond[1] && eq) || (cond[0] && unord);

  always_comb begin
    case (lop)
      L_ABS:   res = {1'b0, a[SGN-1:0]};
      L_NEG:   res = {~a[SGN], a[SGN-1:0]};
      default: res = a;
    endcase
  end
endmodule

// File: rtl/fp_copro_ctrl.sv
module fp_copro_ctrl
  import fpc_pkg::*;
#(
  parameter int unsigned DW   = 32,
  parameter int unsigned NREG = 32,
  parameter int unsigned NSEL = 4,
  parameter int unsigned NBE  = DW / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_i,
  input  logic [DW-1:0]   bus_in,
  input  logic            mem_pause_i,
  input  logic            fpu_ready_i,
  input  logic [DW-1:0]   fpu_result_i,
  output logic            busy_o,
  output logic            stall_o,
  output logic            fp_cond_o,
  output logic [NSEL-1:0] bus_sel_o,
  output logic [DW-1:0]   data_out_o,
  output logic [NBE-1:0]  byte_we_o,
  output logic            fpu_start_o,
  output logic [2:0]      fpu_op_o,
  output logic [DW-1:0]   fpu_opa_o,
  output logic [DW-1:0]   fpu_opb_o
);
  localparam int unsigned RAW = $clog2(NREG);

  state_e        state;
  dec_t          dec_in, ir;
  logic [DW-1:0] opa_q, opb_q, rd_a, rd_b, loc_res, wdata;
  logic          cond_q, cmp_res, we, xfer;
  logic [RAW-1:0] waddr, raddr_a;

  fpc_decode u_dec (.word(bus_in), .dec(dec_in));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      ir     <= '0;
      opa_q  <= '0;
      opb_q  <= '0;
      cond_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (fetch_i) begin
          ir <= dec_in;
          case (dec_in.kind)
            K_EXT, K_LOC: state <= S_OPRD;
            K_NONE:       state <= S_IDLE;
            default:      state <= S_XFER;
          endcase
        end
        S_OPRD: begin
          opa_q <= rd_a;
          opb_q <= rd_b;
          state <= (ir.kind == K_EXT) ? S_START : S_LOCAL;
        end
        S_START: state <= S_WAIT;
        S_WAIT:  if (fpu_ready_i) state <= S_IDLE;
        S_LOCAL: begin
          if (ir.lop == L_CMP) cond_q <= cmp_res;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign xfer = (state == S_XFER);

  always_comb begin
    we    = 1'b0;
    waddr = RAW'(ir.fd);
    wdata = fpu_result_i;
    if (state == S_WAIT && fpu_ready_i) begin
      we = 1'b1;
    end else if (state == S_LOCAL && ir.lop != L_CMP) begin
      we    = 1'b1;
      wdata = loc_res;
    end else if (xfer && (ir.kind == K_MTO || ir.kind == K_LOAD)) begin
      we    = 1'b1;
      waddr = (ir.kind == K_MTO) ? RAW'(ir.fs) : RAW'(ir.ft);
      wdata = bus_in;
    end
  end

  assign raddr_a = (xfer && ir.kind == K_STORE) ? RAW'(ir.ft) : RAW'(ir.fs);

  fpc_regfile #(.W(DW), .DEPTH(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr_a(raddr_a), .rdata_a(rd_a), .raddr_b(RAW'(ir.ft)), .rdata_b(rd_b)
  );

  fpc_local_unit u_loc (
    .lop(ir.lop), .cond(ir.cond), .a(opa_q), .b(opb_q),
    .res(loc_res), .cmp(cmp_res)
  );

  always_comb begin
    bus_sel_o = '0;
    if (xfer) begin
      case (ir.kind)
        K_MFROM: bus_sel_o[0] = 1'b1;
        K_STORE: bus_sel_o[1] = 1'b1;
        K_MTO:   bus_sel_o[2] = 1'b1;
        K_LOAD:  bus_sel_o[3] = 1'b1;
        default: bus_sel_o = '0;
      endcase
    end
  end

  assign busy_o      = (state == S_OPRD) || (state == S_START) ||
                       (state == S_WAIT) || (state == S_LOCAL);
  assign stall_o     = busy_o || mem_pause_i;
  assign fp_cond_o   = cond_q;
  assign data_out_o  = (xfer && (ir.kind == K_MFROM || ir.kind == K_STORE)) ? rd_a : '0;
  assign byte_we_o   = (xfer && ir.kind == K_STORE) ? '1 : '0;
  assign fpu_start_o = (state == S_START);
  assign fpu_op_o    = ir.fop;
  assign fpu_opa_o   = opa_q;
  assign fpu_opb_o   = opb_q;
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_o,
  input logic       fpu_start_o,
  input logic       fp_cond_o,
  input logic [3:0] bus_sel_o,
  input logic [3:0] byte_we_o
);
  // R6
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fpu_start_o |=> !fpu_start_o);
  // R6
  start_staged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fpu_start_o |-> $past(busy_o));
  // R3
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fpu_start_o |-> busy_o);
  // R9
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_sel_o));
  // R9
  sel_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_o != 4'b0) |-> !busy_o);
  // R10
  store_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we_o != 4'b0) |-> (byte_we_o == 4'hF && bus_sel_o == 4'b0010));
  // R8
  cond_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fp_cond_o) |-> $past(busy_o));
endmodule

bind fp_copro_ctrl fpc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .fpu_start_o(fpu_start_o),
  .fp_cond_o(fp_cond_o), .bus_sel_o(bus_sel_o), .byte_we_o(byte_we_o)
);

// File: tb/sim_fp_copro_ctrl.sv
module sim_fp_copro_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, fetch = 1'b0, pause = 1'b0;
  logic [31:0] bus = '0;
  logic ready, busy, stall, cond, start;
  logic [31:0] result, dout, opa, opb;
  logic [3:0] sel, bwe;
  logic [2:0] op;
  int checks = 0, fails = 0, lat = 1, cnt = 0;
  logic [31:0] pend = '0;
  bit done = 0;

  always #4 clk = ~clk;

  fp_copro_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .fetch_i(fetch), .bus_in(bus), .mem_pause_i(pause),
    .fpu_ready_i(ready), .fpu_result_i(result), .busy_o(busy), .stall_o(stall),
    .fp_cond_o(cond), .bus_sel_o(sel), .data_out_o(dout), .byte_we_o(bwe),
    .fpu_start_o(start), .fpu_op_o(op), .fpu_opa_o(opa), .fpu_opb_o(opb)
  );

  // stub arithmetic unit: result = a + b + opcode, ready lat cycles after start
  always_ff @(posedge clk) begin
    if (start) begin
      cnt  <= lat;
      pend <= opa + opb + {29'b0, op};
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
    end
  end
  assign ready  = (cnt == 1);
  assign result = pend;

  function automatic logic [31:0] ari(input logic [5:0] f, input logic [4:0] d, s, t);
    return {6'b010001, 5'b10000, t, s, d, f};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic mto(input logic [4:0] r, input logic [31:0] v);
    @(negedge clk); fetch = 1; bus = {6'b010001, 5'b00100, 5'd0, r, 11'd0};
    @(negedge clk); fetch = 0; bus = v;
    chk("R9 move-to select", {28'b0, sel}, 32'h4);
    @(negedge clk); bus = '0;
  endtask

  task automatic mfrom(input logic [4:0] r, output logic [31:0] v);
    @(negedge clk); fetch = 1; bus = {6'b010001, 5'b00000, 5'd0, r, 11'd0};
    @(negedge clk); fetch = 0; bus = '0;
    v = dout;
    chk("R9 move-from select", {28'b0, sel}, 32'h1);
  endtask

  task automatic exec(input logic [31:0] w, output int nbusy, output int nstart,
                      output int at, output logic [31:0] sa, output int sbad);
    nbusy = 0; nstart = 0; at = -1; sa = '0; sbad = 0;
    @(negedge clk); fetch = 1; bus = w;
    @(negedge clk); fetch = 0; bus = '0;
    for (int k = 0; k < 64; k++) begin
      if (!busy) break;
      nbusy++;
      if (start) begin nstart++; at = k; sa = opa; end
      if (stall !== 1'b1) sbad++;
      @(negedge clk);
    end
  endtask

  localparam int NV = 17;
  localparam logic [101:0] VEC [NV] = '{
    {6'd0,  32'h10, 32'h3, 32'h13},
    {6'd1,  32'h10, 32'h3, 32'h14},
    {6'd2,  32'h10, 32'h3, 32'h15},
    {6'd3,  32'h10, 32'h3, 32'h16},
    {6'd32, 32'h10, 32'h3, 32'h17},
    {6'd36, 32'h10, 32'h3, 32'h18},
    {6'd5,  32'hC0490FDB, 32'h0, 32'h40490FDB},
    {6'd7,  32'h3F800000, 32'h0, 32'hBF800000},
    {6'd6,  32'h12345678, 32'hFFFFFFFF, 32'h12345678},
    {6'd50, 32'h3F800000, 32'h3F800000, 32'h1},
    {6'd50, 32'h80000000, 32'h0, 32'h1},
    {6'd60, 32'hBF800000, 32'h3F800000, 32'h1},
    {6'd60, 32'h3F800000, 32'hBF800000, 32'h0},
    {6'd62, 32'h40000000, 32'h40000000, 32'h1},
    {6'd49, 32'h7FC00000, 32'h0, 32'h1},
    {6'd60, 32'hC0000000, 32'hBF800000, 32'h1},
    {6'd50, 32'h7FC00000, 32'h7FC00000, 32'h0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, sa;
    int nb, ns, at, sb;
    repeat (3) @(negedge clk);
    // R3 R9 R10: reset state
    chk("R3 reset busy", {31'b0, busy}, 0);
    chk("R8 reset cond", {31'b0, cond}, 0);
    chk("R9 reset sel", {28'b0, sel}, 0);
    chk("R10 reset byte enables", {28'b0, bwe}, 0);
    rst_n = 1;
    mfrom(5'd5, v);
    chk("R4 register reset to zero", v, 0);

    // table walk: R5 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic [5:0] f;
      f = VEC[i][101:96];
      mto(5'd1, VEC[i][95:64]);
      mto(5'd2, VEC[i][63:32]);
      exec(ari(f, 5'd3, 5'd1, 5'd2), nb, ns, at, sa, sb);
      if (f >= 6'd48) begin
        chk("R8 compare flag", {31'b0, cond}, VEC[i][31:0]);
        chk("R7 local busy length", nb, 2);
      end else begin
        mfrom(5'd3, v);
        chk(f < 6'd4 || f >= 6'd32 ? "R5 external result" : "R7 local result", v, VEC[i][31:0]);
        chk(f < 6'd4 || f >= 6'd32 ? "R3 busy length" : "R7 local busy length", nb,
            (f < 6'd4 || f >= 6'd32) ? 3 : 2);
      end
    end

    // R6 R3: start timing and latency tracking
    lat = 4;
    mto(5'd4, 32'hAAAA0000);
    mto(5'd6, 32'h00005555);
    exec(ari(6'd0, 5'd8, 5'd4, 5'd6), nb, ns, at, sa, sb);
    chk("R6 single start", ns, 1);
    chk("R6 start in second cycle", at, 1);
    chk("R6 registered operand", sa, 32'hAAAA0000);
    chk("R3 busy follows ready", nb, 6);
    chk("R3 stall during busy", sb, 0);
    mfrom(5'd8, v);
    chk("R5 result after latency", v, 32'hAAAA5555);
    lat = 1;

    // R3: stall from memory pause
    @(negedge clk); pause = 1; @(negedge clk);
    chk("R3 stall from pause", {31'b0, stall}, 1);
    pause = 0; @(negedge clk);
    chk("R3 stall low", {31'b0, stall}, 0);

    // R1: coprocessor word without fetch strobe
    @(negedge clk); bus = ari(6'd0, 5'd8, 5'd4, 5'd6);
    repeat (3) begin
      @(negedge clk);
      chk("R1 no capture without fetch", {31'b0, busy}, 0);
    end
    bus = '0;
    mfrom(5'd8, v);
    chk("R1 register untouched", v, 32'hAAAA5555);

    // R2: non-coprocessor word and unlisted function
    @(negedge clk); fetch = 1; bus = 32'h00221820;
    @(negedge clk); fetch = 0; bus = '0;
    chk("R2 foreign word no busy", {31'b0, busy}, 0);
    chk("R2 foreign word no select", {28'b0, sel}, 0);
    @(negedge clk); fetch = 1; bus = ari(6'd4, 5'd8, 5'd4, 5'd6);
    @(negedge clk); fetch = 0;
    chk("R2 unlisted function no busy", {31'b0, busy}, 0);
    mfrom(5'd8, v);
    chk("R2 unlisted function no write", v, 32'hAAAA5555);

    // R10 R9: store
    mto(5'd7, 32'hDEADBEEF);
    @(negedge clk); fetch = 1; bus = {6'b111001, 5'd2, 5'd7, 16'h0010};
    @(negedge clk); fetch = 0; bus = '0;
    chk("R10 store data", dout, 32'hDEADBEEF);
    chk("R10 store byte enables", {28'b0, bwe}, 32'hF);
    chk("R9 store select", {28'b0, sel}, 32'h2);
    @(negedge clk);
    chk("R10 enables drop", {28'b0, bwe}, 0);

    // R9: load
    @(negedge clk); fetch = 1; bus = {6'b110001, 5'd2, 5'd9, 16'h0020};
    @(negedge clk); fetch = 0; bus = 32'h0BADF00D;
    chk("R9 load select", {28'b0, sel}, 32'h8);
    @(negedge clk); bus = '0;
    mfrom(5'd9, v);
    chk("R9 load written", v, 32'h0BADF00D);

    // R8: flag holds across non-compare operations
    mto(5'd1, 32'h3F800000);
    exec(ari(6'd50, 5'd0, 5'd1, 5'd1), nb, ns, at, sa, sb);
    chk("R8 flag set", {31'b0, cond}, 1);
    exec(ari(6'd0, 5'd10, 5'd1, 5'd1), nb, ns, at, sa, sb);
    chk("R8 flag held", {31'b0, cond}, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule